// File: doc/BRIEF.md
# Sub-word Register Bridge

This block sits between a host port and a set of register targets that can only be accessed a whole, aligned 32-bit word at a time. The host may issue 1-, 2- or 4-byte reads and writes at any byte offset inside a 128-byte window. The bridge decodes the window into three targets: a core block of word-spaced registers, a block of DMA control registers and a single bus-control register. It then turns each host access into the aligned word operations those targets understand.

A read fetches the aligned word and returns it shifted down by the byte offset and masked to the access size. A 4-byte aligned write is forwarded as it is. Any other write becomes an aligned word write built by merging the new bytes into the current value of the target word. For the DMA and control targets, that current value is fetched from the target first. The core target's read side does not reflect what was written to it. For that reason the bridge keeps a shadow copy of the last word written to each core register and merges against the shadow, so no fetch is needed.

The controller is a five-state machine:

| State | Role |
|---|---|
| `ST_IDLE` | Ready for a request. |
| `ST_FETCH` | Issues a target read. |
| `ST_MERGE` | Read data is back; a read captures the extracted result, a write drives the merged word. |
| `ST_WRITE` | Drives a single write with no fetch. |
| `ST_DONE` | Signals completion. |

Its transitions are:

- `ST_IDLE` stays in `ST_IDLE` without a request.
- An accepted request goes from `ST_IDLE` to one of three states:
  - `ST_DONE` for an undecoded offset or an illegal size.
  - `ST_WRITE` for an aligned full-word write, or for any write to the core.
  - `ST_FETCH` otherwise.
- `ST_FETCH` always goes to `ST_MERGE`.
- `ST_MERGE` and `ST_WRITE` always go to `ST_DONE`.
- `ST_DONE` always goes to `ST_IDLE`.

Top module: `subword_reg_bridge`

## Requirements
- R1: After reset, `host_ready` is 1 and `host_done`, `tgt_rd` and `tgt_wr` are 0. Every core shadow word reads as zero. A reset during a transaction abandons it without any target write.
- R2: Word-aligned offsets below 0x40 select the core (`tgt_sel` = 3'b001) at index offset/4. Offsets 0x40 to 0x5F select the DMA block (3'b010) at index (offset-0x40)/4. Offsets 0x70 to 0x73 select the control register (3'b100) at index 0. At most one `tgt_sel` bit is high, and only while `tgt_rd` or `tgt_wr` is high.
- R3: A write with size code 2 (4 bytes) at byte offset 0 produces exactly one target write carrying `host_wdata` unchanged and no target read. `host_done` is high in the second cycle after acceptance.
- R4: Any other decoded write to the core produces one target write and no target read. Its word is the last word written to that core index (zero since reset) with the new bytes merged in. `host_done` is high in the second cycle after acceptance.
- R5: Any other decoded write to the DMA or control target produces one target read followed, in the next cycle, by one target write of the fetched word with the new bytes merged in. `host_done` is high in the third cycle after acceptance.
- R6: Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Only the low 8×size bits of `host_wdata` are used. They land little-endian from byte offset k, so offset k covers word bits 8k+7:8k. Lanes that would fall past the word are dropped.
- R7: A decoded read produces one target read and no write. `host_rdata` equals the fetched word shifted right by 8×offset, then masked to 8×size bits. `host_done` is high in the third cycle after acceptance.
- R8: An access to an undecoded offset (0x60 to 0x6F or 0x74 to 0x7F) causes no target access. `host_done` is high in the first cycle after acceptance, and a read returns zero.
- R9: Size code 3, or a 2-byte access at byte offset 3, is an error. It causes no target access, completes in the first cycle after acceptance and returns zero.
- R10: Requests are accepted only while `host_ready` is high. `host_ready` is low from the cycle after acceptance until the request has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Bridge can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2: 4 B) |
| host_wdata | input | 32 | Write data, right-justified |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with `host_done` |
| tgt_sel | output | 3 | One-hot target select (core, DMA, control) |
| tgt_rd | output | 1 | Aligned word read strobe |
| tgt_wr | output | 1 | Aligned word write strobe |
| tgt_idx | output | 4 | Word index inside the selected target |
| tgt_wdata | output | 32 | Aligned word to write |
| core_rdata | input | 32 | Core read word, valid the cycle after `tgt_rd` |
| dma_rdata | input | 32 | DMA read word, valid the cycle after `tgt_rd` |
| ctl_rdata | input | 32 | Control read word, valid the cycle after `tgt_rd` |

## Verification
Each result has a fixed due cycle, counted from the clock edge that accepts the request:
- Undecoded and illegal accesses complete after one cycle.
- Aligned full-word writes and core writes complete after two cycles.
- Fetching paths complete after three cycles, with the target read in cycle one and the merged write or result capture in cycle two.

The bench drives inputs on the falling edge and counts falling edges from acceptance until `host_done`. That count is checked against the expected latency. It also samples `host_rdata` at that same point. The target strobes are counted on the rising edges in between, so the number of reads and writes each access causes is checked as well as the data of the last write.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    // Access size codes on host_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_MERGE = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } bstate_t;

    // Decoded destination
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CORE = 2'd1,
        TGT_DMA  = 2'd2,
        TGT_CTL  = 2'd3
    } tgt_t;

endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
    import sbw_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int IDX_W    = 4,
    parameter int OFF_W    = 2,
    parameter int CORE_END = 64,
    parameter int DMA_END  = 96,
    parameter int CTL_ADDR = 112
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output tgt_t              tgt,
    output logic [IDX_W-1:0]  idx,
    output logic              bad
);

    localparam int WA_W = ADDR_W - OFF_W;

    logic [WA_W-1:0]  word_addr;
    logic [OFF_W-1:0] off;

    assign word_addr = addr[ADDR_W-1:OFF_W];
    assign off       = addr[OFF_W-1:0];

    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (addr < ADDR_W'(CORE_END)) begin
            tgt = TGT_CORE;
            idx = addr[OFF_W +: IDX_W];
        end else if (addr < ADDR_W'(DMA_END)) begin
            tgt = TGT_DMA;
            idx = addr[OFF_W +: IDX_W] - IDX_W'(CORE_END >> OFF_W);
        end else if (word_addr == WA_W'(CTL_ADDR >> OFF_W)) begin
            tgt = TGT_CTL;
            idx = '0;
        end
    end

    // A half-word that would straddle two words, or the unused size code
    always_comb begin
        bad = (size == SZ_BAD) || ((size == SZ_HALF) && (off == '1));
    end

endmodule

// File: rtl/sbw_lane.sv
module sbw_lane
    import sbw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [1:0]           size,
    input  logic [OFF_W-1:0]     off,
    input  logic [8*LANES-1:0]   new_data,
    input  logic [8*LANES-1:0]   old_word,
    input  logic [8*LANES-1:0]   raw_word,
    output logic [8*LANES-1:0]   merged,
    output logic [8*LANES-1:0]   extracted
);

    localparam int CNT_W  = OFF_W + 1;
    localparam int DATA_W = 8 * LANES;

    logic [CNT_W-1:0]  nbytes;
    logic [CNT_W-1:0]  first;
    logic [CNT_W-1:0]  last_x;
    logic [DATA_W-1:0] up_shift;
    logic [DATA_W-1:0] dn_shift;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = CNT_W'(1);
            SZ_HALF: nbytes = CNT_W'(2);
            default: nbytes = CNT_W'(LANES);
        endcase
    end

    assign first    = {1'b0, off};
    assign last_x   = first + nbytes;
    assign up_shift = new_data << {off, 3'b000};
    assign dn_shift = raw_word >> {off, 3'b000};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic in_write;
        logic in_read;
        assign in_write = (CNT_W'(b) >= first) && (CNT_W'(b) < last_x);
        assign in_read  = CNT_W'(b) < nbytes;
        assign merged[8*b +: 8]    = in_write ? up_shift[8*b +: 8] : old_word[8*b +: 8];
        assign extracted[8*b +: 8] = in_read  ? dn_shift[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/sbw_shadow.sv
module sbw_shadow #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];

    // R4
    shadow_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/subword_reg_bridge.sv
module subword_reg_bridge
    import sbw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 7,
    parameter int CORE_REGS = 16,
    parameter int DMA_REGS  = 8,
    parameter int CORE_END  = 64,
    parameter int DMA_END   = 96,
    parameter int CTL_ADDR  = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [2:0]        tgt_sel,
    output logic              tgt_rd,
    output logic              tgt_wr,
    output logic [3:0]        tgt_idx,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic [DATA_W-1:0] ctl_rdata
);

    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int IDX_W   = 4;
    localparam int CORE_IW = $clog2(CORE_REGS);

    bstate_t state, state_nx;

    // Decode of the presented request
    tgt_t             dec_tgt;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_bad;
    logic             direct_wr;

    // Latched request
    logic              rq_write;
    logic [OFF_W-1:0]  rq_off;
    logic [1:0]        rq_size;
    logic [DATA_W-1:0] rq_wdata;
    tgt_t              rq_tgt;
    logic [IDX_W-1:0]  rq_idx;

    logic              accept;
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] shadow_word;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] extracted;
    logic              shadow_we;

    sbw_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W),
        .CORE_END (CORE_END),
        .DMA_END  (DMA_END),
        .CTL_ADDR (CTL_ADDR)
    ) u_decode (
        .addr (host_addr),
        .size (host_size),
        .tgt  (dec_tgt),
        .idx  (dec_idx),
        .bad  (dec_bad)
    );

    sbw_lane #(
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) u_lane (
        .size      (rq_size),
        .off       (rq_off),
        .new_data  (rq_wdata),
        .old_word  (old_word),
        .raw_word  (raw_word),
        .merged    (merged),
        .extracted (extracted)
    );

    sbw_shadow #(
        .DEPTH  (CORE_REGS),
        .IDX_W  (CORE_IW),
        .DATA_W (DATA_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (shadow_we),
        .wr_idx  (rq_idx[CORE_IW-1:0]),
        .wr_data (tgt_wdata),
        .rd_idx  (rq_idx[CORE_IW-1:0]),
        .rd_data (shadow_word)
    );

    assign accept    = host_valid && (state == ST_IDLE);
    assign direct_wr = ((host_size == SZ_WORD) && (host_addr[OFF_W-1:0] == '0))
                     || (dec_tgt == TGT_CORE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (host_valid) begin
                    if (dec_bad || (dec_tgt == TGT_NONE)) begin
                        state_nx = ST_DONE;
                    end else if (host_write && direct_wr) begin
                        state_nx = ST_WRITE;
                    end else begin
                        state_nx = ST_FETCH;
                    end
                end
            end
            ST_FETCH: state_nx = ST_MERGE;
            ST_MERGE: state_nx = ST_DONE;
            ST_WRITE: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Request capture and read result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_write   <= 1'b0;
            rq_off     <= '0;
            rq_size    <= SZ_BYTE;
            rq_wdata   <= '0;
            rq_tgt     <= TGT_NONE;
            rq_idx     <= '0;
            host_rdata <= '0;
        end else if (accept) begin
            rq_write   <= host_write;
            rq_off     <= host_addr[OFF_W-1:0];
            rq_size    <= host_size;
            rq_wdata   <= host_wdata;
            rq_tgt     <= dec_bad ? TGT_NONE : dec_tgt;
            rq_idx     <= dec_idx;
            host_rdata <= '0;
        end else if ((state == ST_MERGE) && !rq_write) begin
            host_rdata <= extracted;
        end
    end

    // Returned word of the selected target
    always_comb begin
        unique case (rq_tgt)
            TGT_CORE: raw_word = core_rdata;
            TGT_DMA:  raw_word = dma_rdata;
            TGT_CTL:  raw_word = ctl_rdata;
            default:  raw_word = '0;
        endcase
    end

    // Current value to merge against: fetched word or core shadow
    assign old_word  = (state == ST_MERGE) ? raw_word : shadow_word;
    assign shadow_we = tgt_wr && (rq_tgt == TGT_CORE);

    // Output logic
    always_comb begin
        host_ready = 1'b0;
        host_done  = 1'b0;
        tgt_rd     = 1'b0;
        tgt_wr     = 1'b0;
        unique case (state)
            ST_IDLE:  host_ready = 1'b1;
            ST_FETCH: tgt_rd     = 1'b1;
            ST_MERGE: tgt_wr     = rq_write;
            ST_WRITE: tgt_wr     = 1'b1;
            ST_DONE:  host_done  = 1'b1;
            default:  host_ready = 1'b0;
        endcase
        tgt_sel = 3'b000;
        if (tgt_rd || tgt_wr) begin
            unique case (rq_tgt)
                TGT_CORE: tgt_sel = 3'b001;
                TGT_DMA:  tgt_sel = 3'b010;
                TGT_CTL:  tgt_sel = 3'b100;
                default:  tgt_sel = 3'b000;
            endcase
        end
        tgt_idx   = rq_idx;
        tgt_wdata = merged;
    end

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> !host_ready);

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd || tgt_wr) |-> ($countones(tgt_sel) == 1));

    // R5
    fetch_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd && rq_write) |=> (tgt_wr && !tgt_rd && $stable(tgt_sel) && $stable(tgt_idx)));

    // R7
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd && !rq_write) |=> (!tgt_wr && !tgt_rd));

    // R3
    write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |=> host_done);

    // R8
    drop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && (dec_bad || (dec_tgt == TGT_NONE))) |=> (host_done && !tgt_rd && !tgt_wr));

endmodule

// File: tb/subword_reg_bridge_tb_top.sv
module subword_reg_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_write = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_done;
    logic [31:0] host_rdata;
    logic [2:0]  tgt_sel;
    logic        tgt_rd;
    logic        tgt_wr;
    logic [3:0]  tgt_idx;
    logic [31:0] tgt_wdata;
    logic [31:0] core_rdata = '0;
    logic [31:0] dma_rdata = '0;
    logic [31:0] ctl_rdata = '0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    subword_reg_bridge dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .host_done  (host_done),
        .host_rdata (host_rdata),
        .tgt_sel    (tgt_sel),
        .tgt_rd     (tgt_rd),
        .tgt_wr     (tgt_wr),
        .tgt_idx    (tgt_idx),
        .tgt_wdata  (tgt_wdata),
        .core_rdata (core_rdata),
        .dma_rdata  (dma_rdata),
        .ctl_rdata  (ctl_rdata)
    );

    // Target models: core read side is fixed, DMA and control are read/write
    logic [31:0] core_rmem [16];
    logic [31:0] dma_mem [8];
    logic [31:0] ctl_reg = 32'h7777_0000;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [2:0]  last_sel = '0;
    logic [3:0]  last_idx = '0;
    logic [31:0] last_data = '0;

    initial begin
        for (int i = 0; i < 16; i++) core_rmem[i] = {8'hC0, 8'(i), 16'h5A5A};
        for (int i = 0; i < 8; i++) dma_mem[i] = {8'hD0, 8'(i), 16'h1234};
    end

    always @(posedge clk) begin
        if (tgt_rd) begin
            rd_cnt <= rd_cnt + 1;
            if (tgt_sel[0]) core_rdata <= core_rmem[tgt_idx];
            if (tgt_sel[1]) dma_rdata  <= dma_mem[tgt_idx[2:0]];
            if (tgt_sel[2]) ctl_rdata  <= ctl_reg;
        end
        if (tgt_wr) begin
            wr_cnt    <= wr_cnt + 1;
            last_sel  <= tgt_sel;
            last_idx  <= tgt_idx;
            last_data <= tgt_wdata;
            if (tgt_sel[1]) dma_mem[tgt_idx[2:0]] <= tgt_wdata;
            if (tgt_sel[2]) ctl_reg <= tgt_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic wr, input logic [6:0] a, input logic [1:0] sz,
                       input logic [31:0] d, output logic [31:0] rdat,
                       output int lat, output int nrd, output int nwr);
        int r0;
        int w0;
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a; host_size = sz; host_wdata = d;
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        host_valid = 1'b0;
        lat = 1;
        while (!host_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        rdat = host_rdata;
        nrd  = rd_cnt - r0;
        nwr  = wr_cnt - w0;
    endtask

    function automatic logic [2:0] exp_sel(input logic [6:0] a);
        if (a < 7'h40) return 3'b001;
        if (a < 7'h60) return 3'b010;
        if (a[6:2] == 5'h1C) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [3:0] exp_idx(input logic [6:0] a);
        if (a < 7'h40) return a[5:2];
        if (a < 7'h60) return 4'(({2'b00, a} - 9'h40) >> 2);
        return 4'h0;
    endfunction

    // {write, addr, size, data, expected word, latency}
    localparam int NV = 24;
    localparam logic [75:0] VEC [NV] = '{
        {1'b1, 7'h08, 2'd2, 32'h11223344, 32'h11223344, 2'd2},
        {1'b1, 7'h09, 2'd0, 32'h000000AB, 32'h1122AB44, 2'd2},
        {1'b1, 7'h0A, 2'd1, 32'h0000BEEF, 32'hBEEFAB44, 2'd2},
        {1'b1, 7'h13, 2'd0, 32'h0000005C, 32'h5C000000, 2'd2},
        {1'b0, 7'h08, 2'd2, 32'h00000000, 32'hC0025A5A, 2'd3},
        {1'b0, 7'h0B, 2'd0, 32'h00000000, 32'h000000C0, 2'd3},
        {1'b1, 7'h46, 2'd1, 32'h00009876, 32'h98761234, 2'd3},
        {1'b0, 7'h44, 2'd2, 32'h00000000, 32'h98761234, 2'd3},
        {1'b0, 7'h45, 2'd1, 32'h00000000, 32'h00007612, 2'd3},
        {1'b1, 7'h5C, 2'd2, 32'hCAFEF00D, 32'hCAFEF00D, 2'd2},
        {1'b1, 7'h71, 2'd0, 32'h0000003E, 32'h77773E00, 2'd3},
        {1'b0, 7'h72, 2'd1, 32'h00000000, 32'h00007777, 2'd3},
        {1'b0, 7'h60, 2'd2, 32'h00000000, 32'h00000000, 2'd1},
        {1'b1, 7'h64, 2'd2, 32'h12345678, 32'h00000000, 2'd1},
        {1'b1, 7'h43, 2'd1, 32'h0000FFFF, 32'h00000000, 2'd1},
        {1'b0, 7'h0F, 2'd1, 32'h00000000, 32'h00000000, 2'd1},
        {1'b0, 7'h40, 2'd3, 32'h00000000, 32'h00000000, 2'd1},
        {1'b1, 7'h7C, 2'd0, 32'h00000011, 32'h00000000, 2'd1},
        {1'b1, 7'h0D, 2'd2, 32'hAABBCCDD, 32'hBBCCDD00, 2'd2},
        {1'b0, 7'h46, 2'd2, 32'h00000000, 32'h00009876, 2'd3},
        {1'b1, 7'h48, 2'd0, 32'hFFFFFF01, 32'hD0021201, 2'd3},
        {1'b0, 7'h5C, 2'd2, 32'h00000000, 32'hCAFEF00D, 2'd3},
        {1'b0, 7'h70, 2'd2, 32'h00000000, 32'h77773E00, 2'd3},
        {1'b0, 7'h73, 2'd0, 32'h00000000, 32'h00000077, 2'd3}
    };

    initial begin
        logic [31:0] rdat;
        int lat;
        int nrd;
        int nwr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(host_ready == 1'b1, "R1", "ready after reset", 32'(host_ready), 32'd1);
        chk(host_done == 1'b0, "R1", "done after reset", 32'(host_done), 32'd0);
        chk(!tgt_rd && !tgt_wr, "R1", "strobes after reset", {30'd0, tgt_rd, tgt_wr}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [75:0] v;
            logic        vw;
            logic [6:0]  va;
            logic [1:0]  vs;
            logic [31:0] vd;
            logic [31:0] ve;
            int          vl;
            string       tag;
            v  = VEC[i];
            vw = v[75]; va = v[74:68]; vs = v[67:66]; vd = v[65:34]; ve = v[33:2]; vl = int'(v[1:0]);
            if (vl == 1) tag = ((vs == 2'd3) || (vs == 2'd1 && va[1:0] == 2'd3)) ? "R9" : "R8";
            else if (!vw) tag = "R7";
            else if (vs == 2'd2 && va[1:0] == 2'd0) tag = "R3";
            else if (va < 7'h40) tag = "R4 R6";
            else tag = "R5 R6";
            run(vw, va, vs, vd, rdat, lat, nrd, nwr);
            chk(lat == vl, tag, $sformatf("latency vec %0d", i), 32'(lat), 32'(vl));
            chk(nrd == ((vl == 3) ? 1 : 0), tag, $sformatf("read count vec %0d", i), 32'(nrd), 32'((vl == 3) ? 1 : 0));
            if (vw) begin
                chk(nwr == ((vl > 1) ? 1 : 0), tag, $sformatf("write count vec %0d", i), 32'(nwr), 32'((vl > 1) ? 1 : 0));
                if (vl > 1) begin
                    chk(last_data == ve, tag, $sformatf("written word vec %0d", i), last_data, ve);
                    chk(last_sel == exp_sel(va), "R2", $sformatf("select vec %0d", i), 32'(last_sel), 32'(exp_sel(va)));
                    chk(last_idx == exp_idx(va), "R2", $sformatf("index vec %0d", i), 32'(last_idx), 32'(exp_idx(va)));
                end
            end else begin
                chk(nwr == 0, tag, $sformatf("no write on read vec %0d", i), 32'(nwr), 32'd0);
                chk(rdat == ve, tag, $sformatf("read data vec %0d", i), rdat, ve);
            end
        end

        // R10: ready stays low while a fetching access is in flight
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = 7'h44; host_size = 2'd2;
        @(negedge clk);
        chk(host_ready == 1'b0, "R10", "ready in fetch", 32'(host_ready), 32'd0);
        @(negedge clk);
        chk(host_ready == 1'b0, "R10", "ready in merge", 32'(host_ready), 32'd0);
        host_valid = 1'b0;
        @(negedge clk);
        chk(host_done == 1'b1, "R10", "done after busy", 32'(host_done), 32'd1);
        @(negedge clk);
        chk(host_ready == 1'b1 && host_done == 1'b0, "R10", "single completion", {30'd0, host_ready, host_done}, 32'd2);

        // R1: reset in the middle of a fetching write
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = 7'h51; host_size = 2'd0; host_wdata = 32'h000000EE;
        @(negedge clk);
        host_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(host_ready == 1'b1 && host_done == 1'b0, "R1", "ready during reset", {30'd0, host_ready, host_done}, 32'd2);
        chk(!tgt_rd && !tgt_wr, "R1", "strobes during reset", {30'd0, tgt_rd, tgt_wr}, 32'd0);
        rst_n = 1'b1;
        run(1'b0, 7'h50, 2'd2, 32'h0, rdat, lat, nrd, nwr);
        chk(rdat == 32'hD0041234, "R1", "aborted write left target", rdat, 32'hD0041234);
        run(1'b1, 7'h09, 2'd0, 32'h00000077, rdat, lat, nrd, nwr);
        chk(last_data == 32'h00007700, "R1", "shadow cleared by reset", last_data, 32'h00007700);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule